// File: doc/BRIEF.md
# Watchdog Key Sequence and Lock Controller

This block sits between a register write port and a watchdog timeout counter. It watches 16-bit writes to the service address and tracks two independent two-write sequences. One sequence releases the soft configuration lock. The other sequence produces a one-cycle service pulse, which reloads the timeout counter elsewhere in the chip. Service keys are either a fixed pair or a stream drawn from a 16-bit linear congruential generator. The generator state (the seed) is held here and can be read out.

The block also owns the soft-lock and hard-lock bits. It produces gated write grants for the control, timeout and window registers, which live outside the block. It applies the same gating to software writes of its own seed register. The key-mode and enable bits arrive as inputs from the control register.

Address map (parameters, defaults shown): control 0, timeout 1, window 2, service 3, seed 4.

Top module: `wdk_key_lock`

## Requirements
- R1: After reset, lock_soft and lock_hard are 0, seed equals SEED_INIT (default 0x0000) and svc_pulse is 0.
- R2: An unlocked write to the control address sets lock_soft when wr_data bit 0 is 1, and sets lock_hard when wr_data bit 1 is 1. The new lock value is visible the cycle after the write.
- R3: Once set, lock_hard stays 1 until reset, whatever is written.
- R4: While either lock bit is 1, writes to the control, timeout, window and seed addresses have no effect. reg_we stays 0 and seed does not change. While both lock bits are 0, reg_we bit 0/1/2 is high in the same cycle as a write to the control/timeout/window address, and a seed-address write loads seed on the next cycle.
- R5: A service-address write of 0xC520 followed later by 0xD928 clears lock_soft. This holds with any number of idle cycles between the two writes and with enable low. It leaves lock_hard unchanged.
- R6: The unlock tracker ignores writes that belong to the service sequence. In fixed mode these are 0xA602 and 0xB480; in keyed mode these are accepted keys. Any other value except 0xC520 aborts a pending unlock. A new 0xC520 always arms the tracker again.
- R7: With key_mode 0, service-address writes of 0xA602 then 0xB480 give svc_pulse high for exactly the one cycle after the 0xB480 write. Any gap between the two writes is allowed.
- R8: The service tracker ignores 0xC520 and 0xD928 when they are not the expected key. In fixed mode, 0xA602 written while waiting for 0xB480 keeps the tracker waiting for 0xB480. Any other wrong value returns the tracker to its first step.
- R9: With key_mode 1, each expected key is (17 × seed + 3) mod 65536. seed takes the value of every accepted key. From seed 0x0100 the keys are 0x1103 then 0x2136. The seed then reads 0x2136, and the next pair is 0x3499 then 0x7E2C.
- R10: svc_pulse is raised only if enable is 1 in the cycle of the completing write. The sequence is still consumed when enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (3) | Write address |
| wr_data | input | KEY_W (16) | Write data |
| key_mode | input | 1 | 1 selects generated keys, 0 the fixed pair |
| enable | input | 1 | Watchdog enable; gates the service pulse |
| svc_pulse | output | 1 | One-cycle counter reload request |
| lock_soft | output | 1 | Soft lock state |
| lock_hard | output | 1 | Hard lock state |
| seed | output | KEY_W (16) | Current generator state |
| reg_we | output | 3 | Granted writes: bit 0 control, bit 1 timeout, bit 2 window |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that wr_en, wr_addr, wr_data, key_mode and enable are known and steady around each rising edge. They treat the control fields and key_mode as ordinary inputs that may change between the two writes of a sequence. The stimulus is always driven on the falling edge, so these assumptions hold. Directed passes cover both sequences, gaps, interleaving and aborts. These are followed by a long burst of pseudo-random writes drawn from the key, unlock and noise values, with key_mode and enable toggled during the burst.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned KEY_W = 16;
  typedef logic [KEY_W-1:0] key_t;

  localparam key_t UNLOCK_FIRST = 16'hC520;
  localparam key_t UNLOCK_SECOND = 16'hD928;
  localparam key_t SVC_FIRST = 16'hA602;
  localparam key_t SVC_SECOND = 16'hB480;

  typedef enum logic {TRK_IDLE = 1'b0, TRK_ARMED = 1'b1} trk_e;

  // Next generator state, modulo 2^KEY_W by truncation.
  function automatic key_t lcg_step(input key_t s, input int unsigned mul, input int unsigned inc);
    key_t r;
    r = key_t'(s * key_t'(mul)) + key_t'(inc);
    return r;
  endfunction
endpackage

// File: rtl/wdk_unlock_trk.sv
module wdk_unlock_trk
  import wdk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic svc_wr,
  input  key_t wr_data,
  input  logic svc_value,
  output logic unlock_done
);
  trk_e st;
  logic hit_first, hit_second;

  assign hit_first = svc_wr && (wr_data == UNLOCK_FIRST);
  assign hit_second = svc_wr && (st == TRK_ARMED) && (wr_data == UNLOCK_SECOND);
  assign unlock_done = hit_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= TRK_IDLE;
    else if (hit_second) st <= TRK_IDLE;
    else if (hit_first) st <= TRK_ARMED;
    else if (svc_wr && !svc_value) st <= TRK_IDLE;
  end

  // R6: completing the unlock always leaves the tracker idle
  assert_unlock_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_done && wr_data != UNLOCK_FIRST) |=> !unlock_done);
endmodule

// File: rtl/wdk_service_trk.sv
module wdk_service_trk
  import wdk_pkg::*;
#(
  parameter int unsigned LCG_MUL = 17,
  parameter int unsigned LCG_INC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_wr,
  input  key_t wr_data,
  input  logic key_mode,
  input  logic enable,
  input  key_t seed,
  output logic key_hit,
  output logic svc_value,
  output logic svc_pulse
);
  trk_e st;
  key_t expect_key;
  logic complete, is_unlock_val;

  always_comb begin
    if (key_mode) expect_key = lcg_step(seed, LCG_MUL, LCG_INC);
    else if (st == TRK_ARMED) expect_key = SVC_SECOND;
    else expect_key = SVC_FIRST;
  end

  assign key_hit = svc_wr && (wr_data == expect_key);
  assign complete = key_hit && (st == TRK_ARMED);
  assign is_unlock_val = (wr_data == UNLOCK_FIRST) || (wr_data == UNLOCK_SECOND);
  assign svc_value = key_mode ? key_hit : ((wr_data == SVC_FIRST) || (wr_data == SVC_SECOND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TRK_IDLE;
      svc_pulse <= 1'b0;
    end else begin
      svc_pulse <= complete && enable;
      if (key_hit) st <= complete ? TRK_IDLE : TRK_ARMED;
      else if (svc_wr) begin
        if (!key_mode && wr_data == SVC_FIRST) st <= TRK_ARMED;
        else if (!is_unlock_val) st <= TRK_IDLE;
      end
    end
  end

  assert_pulse_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |-> $past(enable));
  assert_pulse_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |-> $past(svc_wr));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |=> !svc_pulse);
endmodule

// File: rtl/wdk_lock_regs.sv
module wdk_lock_regs
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ADDR_CTRL = 0,
  parameter int unsigned ADDR_TMO = 1,
  parameter int unsigned ADDR_WIN = 2,
  parameter int unsigned ADDR_SEED = 4,
  parameter int unsigned SLK_BIT = 0,
  parameter int unsigned HLK_BIT = 1,
  parameter key_t SEED_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  key_t              wr_data,
  input  logic              unlock_done,
  input  logic              key_hit,
  input  logic              key_mode,
  output logic              lock_soft,
  output logic              lock_hard,
  output key_t              seed,
  output logic [2:0]        reg_we
);
  localparam int unsigned N_GRANT = 3;
  logic wr_open, seed_grant;

  assign wr_open = !(lock_soft || lock_hard);
  assign seed_grant = wr_en && wr_open && (wr_addr == ADDR_W'(ADDR_SEED));

  for (genvar g = 0; g < N_GRANT; g++) begin : g_grant
    localparam int unsigned GA = (g == 0) ? ADDR_CTRL : ((g == 1) ? ADDR_TMO : ADDR_WIN);
    assign reg_we[g] = wr_en && wr_open && (wr_addr == ADDR_W'(GA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_soft <= 1'b0;
      lock_hard <= 1'b0;
      seed <= SEED_INIT;
    end else begin
      if (reg_we[0] && wr_data[HLK_BIT]) lock_hard <= 1'b1;
      if (unlock_done) lock_soft <= 1'b0;
      else if (reg_we[0] && wr_data[SLK_BIT]) lock_soft <= 1'b1;
      if (key_hit && key_mode) seed <= wr_data;
      else if (seed_grant) seed <= wr_data;
    end
  end

  assert_hard_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hard |=> lock_hard);
  assert_soft_clear_by_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_soft) |-> $past(unlock_done));
  assert_seed_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seed) |-> $past(key_hit || seed_grant));
endmodule

// File: rtl/wdk_key_lock.sv
module wdk_key_lock
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ADDR_CTRL = 0,
  parameter int unsigned ADDR_TMO = 1,
  parameter int unsigned ADDR_WIN = 2,
  parameter int unsigned ADDR_SVC = 3,
  parameter int unsigned ADDR_SEED = 4,
  parameter int unsigned SLK_BIT = 0,
  parameter int unsigned HLK_BIT = 1,
  parameter int unsigned LCG_MUL = 17,
  parameter int unsigned LCG_INC = 3,
  parameter key_t SEED_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic              key_mode,
  input  logic              enable,
  output logic              svc_pulse,
  output logic              lock_soft,
  output logic              lock_hard,
  output logic [KEY_W-1:0]  seed,
  output logic [2:0]        reg_we
);
  logic svc_wr, key_hit, svc_value, unlock_done;

  assign svc_wr = wr_en && (wr_addr == ADDR_W'(ADDR_SVC));

  wdk_service_trk #(.LCG_MUL(LCG_MUL), .LCG_INC(LCG_INC)) u_svc (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wr_data(wr_data),
    .key_mode(key_mode), .enable(enable), .seed(seed),
    .key_hit(key_hit), .svc_value(svc_value), .svc_pulse(svc_pulse)
  );

  wdk_unlock_trk u_unl (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wr_data(wr_data),
    .svc_value(svc_value), .unlock_done(unlock_done)
  );

  wdk_lock_regs #(
    .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_TMO(ADDR_TMO), .ADDR_WIN(ADDR_WIN),
    .ADDR_SEED(ADDR_SEED), .SLK_BIT(SLK_BIT), .HLK_BIT(HLK_BIT), .SEED_INIT(SEED_INIT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlock_done(unlock_done), .key_hit(key_hit), .key_mode(key_mode),
    .lock_soft(lock_soft), .lock_hard(lock_hard), .seed(seed), .reg_we(reg_we)
  );

  // R5: unlock completion never touches the hard lock
  assert_unlock_keeps_hard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_done && lock_hard) |=> lock_hard);
endmodule

// File: tb/wdk_key_lock_bench.sv
module wdk_key_lock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic key_mode = 1'b0;
  logic enable = 1'b1;
  logic svc_pulse, lock_soft, lock_hard;
  logic [15:0] seed;
  logic [2:0] reg_we;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wdk_key_lock u_wdk_key_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_mode(key_mode), .enable(enable), .svc_pulse(svc_pulse),
    .lock_soft(lock_soft), .lock_hard(lock_hard), .seed(seed), .reg_we(reg_we)
  );

  // Behavioural reference model, updated on each rising edge
  int m_seed, m_pulse, m_soft, m_hard, m_unl_armed, m_svc_armed;

  function automatic int next_key(input int s);
    return (s * 17 + 3) % 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_seed = 0; m_pulse = 0; m_soft = 0; m_hard = 0; m_unl_armed = 0; m_svc_armed = 0;
    end else begin
      int d, want;
      bit open, good, belongs;
      d = int'(wr_data);
      open = (m_soft == 0) && (m_hard == 0);
      m_pulse = 0;
      if (wr_en) begin
        if (wr_addr == 3'd0 && open) begin
          if (d % 2 == 1) m_soft = 1;
          if ((d / 2) % 2 == 1) m_hard = 1;
        end
        if (wr_addr == 3'd4 && open) m_seed = d;
        if (wr_addr == 3'd3) begin
          if (key_mode) want = next_key(m_seed);
          else want = (m_svc_armed != 0) ? 'hB480 : 'hA602;
          good = (d == want);
          belongs = key_mode ? good : (d == 'hA602 || d == 'hB480);
          if (m_unl_armed != 0 && d == 'hD928) begin m_soft = 0; m_unl_armed = 0; end
          else if (d == 'hC520) m_unl_armed = 1;
          else if (!belongs) m_unl_armed = 0;
          if (good) begin
            if (m_svc_armed != 0) begin m_pulse = enable ? 1 : 0; m_svc_armed = 0; end
            else m_svc_armed = 1;
            if (key_mode) m_seed = d;
          end else if (!key_mode && d == 'hA602) m_svc_armed = 1;
          else if (d != 'hC520 && d != 'hD928) m_svc_armed = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Registered outputs compared with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 R10 svc_pulse", int'(svc_pulse), m_pulse);
      chk("R2 R5 lock_soft", int'(lock_soft), m_soft);
      chk("R3 lock_hard", int'(lock_hard), m_hard);
      chk("R9 R4 seed", int'(seed), m_seed);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    int exp_we;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    exp_we = (m_soft == 0 && m_hard == 0 && a < 3) ? (1 << a) : 0;
    chk("R4 reg_we", int'(reg_we), exp_we);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    logic [15:0] pool [8];
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 reset lock_soft", int'(lock_soft), 0);
    chk("R1 reset lock_hard", int'(lock_hard), 0);
    chk("R1 reset seed", int'(seed), 0);
    chk("R1 reset svc_pulse", int'(svc_pulse), 0);

    // R7 fixed service with gap and interleaved unlock value (R8)
    wr(3, 16'hA602); idle(4);
    wr(3, 16'hC520);
    wr(3, 16'hB480);
    chk("R7 fixed pulse", int'(svc_pulse), 1);
    idle(1);
    chk("R7 pulse one cycle", int'(svc_pulse), 0);
    // R8 restart and abort
    wr(3, 16'hA602); wr(3, 16'hA602); wr(3, 16'hB480);
    chk("R8 restart pulse", int'(svc_pulse), 1);
    wr(3, 16'hA602); wr(3, 16'h1234); wr(3, 16'hB480);
    chk("R8 abort no pulse", int'(svc_pulse), 0);
    // R10 enable low
    enable = 1'b0;
    wr(3, 16'hA602); wr(3, 16'hB480);
    chk("R10 no pulse when disabled", int'(svc_pulse), 0);
    enable = 1'b1;
    wr(3, 16'hB480);
    chk("R10 sequence consumed", int'(svc_pulse), 0);

    // R9 keyed example
    wr(4, 16'h0100);
    chk("R4 seed load", int'(seed), 'h0100);
    key_mode = 1'b1;
    wr(3, 16'h1103);
    chk("R9 seed after first key", int'(seed), 'h1103);
    wr(3, 16'h2136);
    chk("R9 keyed pulse", int'(svc_pulse), 1);
    chk("R9 seed after pair", int'(seed), 'h2136);
    wr(3, 16'h3499); wr(3, 16'h7E2C);
    chk("R9 second pair pulse", int'(svc_pulse), 1);
    chk("R9 seed second pair", int'(seed), 'h7E2C);
    wr(3, 16'hA602);
    chk("R9 fixed value rejected in keyed mode", int'(seed), 'h7E2C);
    key_mode = 1'b0;

    // R2 soft lock, R4 gating, R5 unlock, R6 ignore/abort
    wr(0, 16'h0001);
    chk("R2 soft set", int'(lock_soft), 1);
    wr(4, 16'h5555);
    chk("R4 seed write ignored", int'(seed), 'h7E2C);
    wr(1, 16'h0010); wr(2, 16'h0020);
    wr(3, 16'hC520); wr(3, 16'h9999); wr(3, 16'hD928);
    chk("R6 abort keeps lock", int'(lock_soft), 1);
    enable = 1'b0;
    wr(3, 16'hC520); idle(5); wr(3, 16'hA602); wr(3, 16'hB480); wr(3, 16'hD928);
    chk("R5 R6 unlock across service writes", int'(lock_soft), 0);
    enable = 1'b1;
    wr(0, 16'h0001);
    wr(3, 16'hC520); wr(3, 16'hC520); wr(3, 16'hD928);
    chk("R6 rearm unlock", int'(lock_soft), 0);

    // R3 hard lock
    wr(0, 16'h0003);
    chk("R2 hard set", int'(lock_hard), 1);
    wr(3, 16'hC520); wr(3, 16'hD928);
    chk("R5 soft cleared", int'(lock_soft), 0);
    chk("R3 hard kept", int'(lock_hard), 1);
    wr(0, 16'h0000);
    chk("R3 hard after control write", int'(lock_hard), 1);
    do_reset();
    chk("R3 hard cleared by reset", int'(lock_hard), 0);

    // Pseudo-random burst against the model
    pool[0] = 16'hA602; pool[1] = 16'hB480; pool[2] = 16'hC520; pool[3] = 16'hD928;
    pool[4] = 16'h0003; pool[5] = 16'h0000; pool[6] = 16'h0001; pool[7] = 16'h4242;
    r = 7;
    for (int i = 0; i < 600; i++) begin
      int a, v;
      r = (r * 1103515245 + 12345) & 32'h7fffffff;
      a = (r >> 8) % 8;
      v = (r >> 12) % 8;
      if ((r >> 20) % 16 == 0) key_mode = ~key_mode;
      if ((r >> 24) % 8 == 0) enable = ~enable;
      if ((r >> 4) % 97 == 0) do_reset();
      if (a < 5) begin
        logic [15:0] d;
        d = pool[v];
        if (key_mode && v == 7) d = 16'(next_key(m_seed));
        if (a == 0 && v == 4) d = 16'h0001;
        wr(3'(a == 4 ? 3 : a), d);
      end else if (a == 5) wr(3'd4, 16'(r >> 3));
      else idle(1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule